// File: doc/BRIEF.md
# Antenna-Carrier Receive Buffer

This block sits between the receive side of a radio link and an application that consumes IQ sample words for one antenna-carrier channel. The link side pushes words into a small circular store. The application takes them out in one of three ways. In FIFO mode, the application asks for words with a read request. In synchronous buffer mode, it can also realign the read position to the start of the store with a resync pulse. In internally-clocked mode, the block drains the store by itself and flags the first word of every radio frame.

A packed 3-bit status vector reports three things. Two of them are sticky error flags: one for writes that were lost because the store was full, and one for reads that were asked for while the store was empty. The third bit echoes the channel enable. Disabling the channel flushes the store.

Both sides run on one clock in this model. The application must only pulse resync once the link reports that receive data has started. The block does not check this.

Top module: `axc_rx_buffer`

## Requirements
- R1: `mode_sel` selects the mode as follows: 0 = FIFO, 1 = synchronous buffer, 2 = internally-clocked. The value 3 behaves as FIFO.
- R2: In FIFO and synchronous buffer modes, each accepted read request returns words in the order they were written. `rd_valid` is high and `rd_data` holds the word in the cycle after the request edge.
- R3: A write that arrives while the store holds DEPTH words is discarded. Status bit 2 goes high after that edge and stays high until a `clr_status` pulse. If a new overflow and a clear arrive in the same cycle, the set wins.
- R4: A read request that arrives while the store is empty returns nothing. `rd_valid` stays low and `rd_data` keeps its last value. Status bit 1 goes high after that edge and stays high until a `clr_status` pulse, with set winning over clear.
- R5: In synchronous buffer mode, a `resync` pulse moves the read position to slot 0. The occupancy becomes the current write slot index, plus one if a write is accepted in the same cycle. No read is performed in that cycle.
- R6: `resync` has no effect in FIFO mode or in internally-clocked mode.
- R7: In internally-clocked mode, the block reads one word per cycle whenever the store is non-empty, and `rd_en` is ignored. `frame_start` is high together with `rd_valid` on delivered words 0, FRAME_LEN, 2·FRAME_LEN, and so on. Words are counted from the moment the channel was enabled in this mode.
- R8: In FIFO and synchronous buffer modes, `frame_start` stays low.
- R9: Status bit 0 equals `chan_en` as it was one cycle earlier.
- R10: While `chan_en` is low, the block ignores writes and read requests and raises no flag. `rd_valid` is low, and the store is emptied, with both positions set back to slot 0.
- R11: After reset, `rd_valid`, `frame_start`, `rd_data` and all status bits are zero.
- R12: The full check uses the occupancy before the edge. A write to a full store is dropped even when a read happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by link and application sides |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Synchronization mode select |
| chan_en | input | 1 | Channel enable |
| clr_status | input | 1 | Clears the sticky overflow and underflow flags |
| wr_en | input | 1 | Link-side write strobe |
| wr_data | input | WIDTH | Link-side IQ word |
| rd_en | input | 1 | Application read request (FIFO and synchronous buffer modes) |
| resync | input | 1 | Read-position realign pulse (synchronous buffer mode) |
| rd_data | output | WIDTH | Delivered IQ word |
| rd_valid | output | 1 | `rd_data` carries a new word this cycle |
| frame_start | output | 1 | First word of a radio frame (internally-clocked mode) |
| status | output | 3 | {overflow, underflow, enable} |

## Verification
The bench builds the block with WIDTH 16, DEPTH 8 and FRAME_LEN 5. The shallow store means overflow, the full-plus-read collision and pointer wrap-around are all reached within a dozen writes. The short frame produces several frame boundaries in one burst of twelve words, which is enough to check the start-pulse spacing and the counter wrap. A randomized phase then switches among all four mode codes while resync, clears and enable changes are applied. This exercises the occupancy reload after resync at many different write positions.

// File: rtl/axc_rx_pkg.sv
// Shared definitions for the antenna-carrier receive buffer.
// Assumes: mode codes are fixed by the configuration input encoding.
package axc_rx_pkg;
    typedef enum logic [1:0] {
        MODE_FIFO   = 2'd0,
        MODE_SYNC   = 2'd1,
        MODE_INTCLK = 2'd2,
        MODE_SPARE  = 2'd3
    } rx_mode_e;

    localparam int STAT_OVF = 2;
    localparam int STAT_UDF = 1;
    localparam int STAT_EN  = 0;
endpackage

// File: rtl/axc_rx_store.sv
// Word storage for the receive buffer: one write port, one combinational read port.
// Assumes: the caller never writes and reads the same slot in one cycle with
// conflicting intent (the occupancy logic guarantees this).
module axc_rx_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     wr_ok,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [WIDTH-1:0]         rd_word
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store an accepted word at the write slot.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_addr] <= wr_data;
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/axc_rx_ptrs.sv
// Write/read positions and occupancy count, with accept/drop/miss decisions.
// Assumes: DEPTH is a power of two; requests arrive already gated by enable.
module axc_rx_ptrs #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chan_en,
    input  logic                     wr_req,
    input  logic                     rd_req,
    input  logic                     rs_req,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic                     wr_ok,
    output logic                     rd_ok,
    output logic                     wr_drop,
    output logic                     rd_miss,
    output logic                     empty
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = ADDR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] cnt;
    logic             full;

    assign full    = (cnt == FULL_CNT);
    assign empty   = (cnt == '0);
    assign wr_ok   = wr_req && !full;
    assign wr_drop = wr_req && full;
    assign rd_ok   = rd_req && !empty && !rs_req;
    assign rd_miss = rd_req && empty && !rs_req;

    // Advance positions and occupancy; flush while disabled, reload on resync.
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) begin
            wr_addr <= '0;
            rd_addr <= '0;
            cnt     <= '0;
        end else begin
            wr_addr <= wr_addr + ADDR_W'(wr_ok);
            if (rs_req) begin
                rd_addr <= '0;
                cnt     <= {1'b0, wr_addr} + CNT_W'(wr_ok);
            end else begin
                rd_addr <= rd_addr + ADDR_W'(rd_ok);
                cnt     <= cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
            end
        end
    end
endmodule

// File: rtl/axc_rx_frame.sv
// Tracks the position of delivered words inside a radio frame.
// Assumes: 'run' is low whenever the frame count must restart.
module axc_rx_frame #(
    parameter int FRAME_LEN = 1920
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic adv,
    output logic at_first
);
    generate
        if (FRAME_LEN <= 1) begin : g_every
            assign at_first = 1'b1;
        end else begin : g_count
            localparam int POS_W = $clog2(FRAME_LEN);
            localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);
            logic [POS_W-1:0] pos;

            // Count delivered words, wrapping at the frame length.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) pos <= '0;
                else if (adv)       pos <= (pos == LAST) ? '0 : pos + 1'b1;
            end

            assign at_first = (pos == '0);
        end
    endgenerate
endmodule

// File: rtl/axc_rx_flags.sv
// Sticky overflow/underflow flags and the registered enable echo.
// Assumes: a set and a clear in the same cycle resolve to set.
module axc_rx_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_ovf,
    input  logic       set_udf,
    input  logic       chan_en,
    output logic [2:0] status
);
    logic ovf, udf, en_q;

    // Hold error flags until cleared; sample the enable every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf  <= 1'b0;
            udf  <= 1'b0;
            en_q <= 1'b0;
        end else begin
            ovf  <= set_ovf | (ovf & ~clr);
            udf  <= set_udf | (udf & ~clr);
            en_q <= chan_en;
        end
    end

    assign status = {ovf, udf, en_q};
endmodule

// File: rtl/axc_rx_buffer.sv
// Receive buffer for one antenna-carrier channel with three synchronization
// modes (FIFO, resync-realigned, self-paced with frame-start marking).
// Assumes: one clock for both sides; resync is only pulsed after the link
// reports receive start (not checked here).
module axc_rx_buffer
    import axc_rx_pkg::*;
#(
    parameter int WIDTH     = 32,
    parameter int DEPTH     = 16,
    parameter int FRAME_LEN = 1920
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             chan_en,
    input  logic             clr_status,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic             resync,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             frame_start,
    output logic [2:0]       status
);
    localparam int ADDR_W = $clog2(DEPTH);

    rx_mode_e          mode;
    logic              auto_rd, wr_req, rd_req, rs_req;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_ok, rd_ok, wr_drop, rd_miss, empty, at_first;
    logic [WIDTH-1:0]  rd_word;

    assign mode    = rx_mode_e'(mode_sel);
    assign auto_rd = (mode == MODE_INTCLK);
    assign wr_req  = chan_en && wr_en;
    assign rd_req  = chan_en && (auto_rd ? !empty : rd_en);
    assign rs_req  = chan_en && (mode == MODE_SYNC) && resync;

    axc_rx_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .wr_req  (wr_req),
        .rd_req  (rd_req),
        .rs_req  (rs_req),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .wr_drop (wr_drop),
        .rd_miss (rd_miss),
        .empty   (empty)
    );

    axc_rx_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_ok   (wr_ok),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    axc_rx_frame #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (chan_en && auto_rd),
        .adv      (rd_ok),
        .at_first (at_first)
    );

    axc_rx_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_status),
        .set_ovf (wr_drop),
        .set_udf (rd_miss),
        .chan_en (chan_en),
        .status  (status)
    );

    // Register the delivered word, its valid and the frame-start mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data     <= '0;
            rd_valid    <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            rd_valid    <= rd_ok;
            frame_start <= rd_ok && auto_rd && at_first;
            if (rd_ok) rd_data <= rd_word;
        end
    end
endmodule

// File: rtl/axc_rx_buffer_chk.sv
// Port-level temporal checks for the receive buffer, bound to every instance.
// Assumes: synchronous active-low reset on rst_n.
module axc_rx_buffer_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             chan_en,
    input logic             clr_status,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_valid,
    input logic             frame_start,
    input logic [2:0]       status
);
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !clr_status) |=> status[2]);

    p_clear_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !chan_en) |=> (status[2:1] == 2'b00));

    p_udf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !clr_status) |=> status[1]);

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> $stable(rd_data));

    p_start_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> rd_valid);

    p_start_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel != 2'd2) |=> !frame_start);

    p_en_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[0] == $past(chan_en)));

    p_no_valid_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> !rd_valid);
endmodule

bind axc_rx_buffer axc_rx_buffer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .chan_en     (chan_en),
    .clr_status  (clr_status),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .frame_start (frame_start),
    .status      (status)
);

// File: tb/axc_rx_buffer_test.sv
// Bench: behavioural reference model updated every clock and compared after each edge.
module axc_rx_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int D = 8;
    localparam int F = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_sel = 2'd0;
    logic         chan_en = 1'b0, clr_status = 1'b0, wr_en = 1'b0, rd_en = 1'b0, resync = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         rd_valid, frame_start;
    logic [2:0]   status;

    int checks = 0, errors = 0;
    int n_valid = 0, n_start = 0;
    bit done = 1'b0;

    // reference model state
    int m_mem [D];
    int m_wa = 0, m_ra = 0, m_cnt = 0, m_pos = 0;
    int m_data = 0;
    bit m_valid = 0, m_start = 0, m_ovf = 0, m_udf = 0, m_en = 0;

    axc_rx_buffer #(.WIDTH(W), .DEPTH(D), .FRAME_LEN(F)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .chan_en(chan_en),
        .clr_status(clr_status), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .resync(resync), .rd_data(rd_data), .rd_valid(rd_valid),
        .frame_start(frame_start), .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Next model state from current state and the inputs present before the edge.
    task automatic model_update();
        bit autom, full, empty, rs, wok, rok, drop, miss, rreq;
        int old_wa;
        if (!rst_n) begin
            m_wa = 0; m_ra = 0; m_cnt = 0; m_pos = 0; m_data = 0;
            m_valid = 0; m_start = 0; m_ovf = 0; m_udf = 0; m_en = 0;
            return;
        end
        autom = (mode_sel == 2'd2);
        full  = (m_cnt == D);
        empty = (m_cnt == 0);
        rs    = chan_en && (mode_sel == 2'd1) && resync;
        wok   = chan_en && wr_en && !full;
        drop  = chan_en && wr_en && full;
        rreq  = chan_en && (autom ? !empty : rd_en);
        rok   = rreq && !empty && !rs;
        miss  = rreq && empty && !rs;
        m_valid = rok;
        m_start = rok && autom && (m_pos == 0);
        if (rok) m_data = m_mem[m_ra];
        if (wok) m_mem[m_wa] = int'(wr_data);
        old_wa = m_wa;
        if (!chan_en) begin
            m_wa = 0; m_ra = 0; m_cnt = 0;
        end else begin
            m_wa = (m_wa + int'(wok)) % D;
            if (rs) begin
                m_ra = 0; m_cnt = old_wa + int'(wok);
            end else begin
                m_ra = (m_ra + int'(rok)) % D;
                m_cnt = m_cnt + int'(wok) - int'(rok);
            end
        end
        if (!chan_en || !autom) m_pos = 0;
        else if (rok) m_pos = (m_pos == F-1) ? 0 : m_pos + 1;
        m_ovf = drop ? 1'b1 : (clr_status ? 1'b0 : m_ovf);
        m_udf = miss ? 1'b1 : (clr_status ? 1'b0 : m_udf);
        m_en  = chan_en;
    endtask

    // One clock: update the model, take the edge, compare a quarter period later.
    task automatic step();
        model_update();
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk("R2 rd_valid", int'(rd_valid), int'(m_valid));
        chk("R2 rd_data", int'(rd_data), m_data);
        chk("R7 frame_start", int'(frame_start), int'(m_start));
        chk("R3 status[2]", int'(status[2]), int'(m_ovf));
        chk("R4 status[1]", int'(status[1]), int'(m_udf));
        chk("R9 status[0]", int'(status[0]), int'(m_en));
        if (rd_valid) n_valid++;
        if (frame_start) n_start++;
    endtask

    task automatic push(int v);
        wr_en = 1'b1; wr_data = W'(v); step(); wr_en = 1'b0;
    endtask

    task automatic pull();
        rd_en = 1'b1; step(); rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        // R11: reset state
        step(); step();
        chk("R11 rd_valid reset", int'(rd_valid), 0);
        chk("R11 rd_data reset", int'(rd_data), 0);
        chk("R11 frame_start reset", int'(frame_start), 0);
        chk("R11 status reset", int'(status), 0);
        rst_n = 1'b1; chan_en = 1'b1; mode_sel = 2'd0;
        step();

        // R1 / R2: FIFO order
        push(11); push(22); push(33);
        pull(); chk("R2 first word", int'(rd_data), 11); chk("R2 valid", int'(rd_valid), 1);
        pull(); chk("R2 second word", int'(rd_data), 22);
        pull(); chk("R2 third word", int'(rd_data), 33);
        // R4: underflow
        pull();
        chk("R4 no valid on empty", int'(rd_valid), 0);
        chk("R4 data held", int'(rd_data), 33);
        chk("R4 underflow flag", int'(status[1]), 1);
        step(); chk("R4 flag sticky", int'(status[1]), 1);
        clr_status = 1'b1; step(); clr_status = 1'b0;
        chk("R3 clear", int'(status[2:1]), 0);

        // R3 / R12: overflow and full-with-read collision
        for (int i = 1; i <= D; i++) push(i);
        push(99);
        chk("R3 overflow flag", int'(status[2]), 1);
        rd_en = 1'b1; push(77); rd_en = 1'b0;
        chk("R12 read during full", int'(rd_data), 1);
        for (int i = 2; i <= D; i++) pull();
        chk("R12 last stored word", int'(rd_data), D);
        pull();
        chk("R12 dropped word absent", int'(rd_valid), 0);
        chk("R3 overflow sticky", int'(status[2]), 1);
        clr_status = 1'b1; step(); clr_status = 1'b0;

        // R6: resync ignored in FIFO mode (also code 3 behaves as FIFO, R1)
        mode_sel = 2'd3;
        push(5); push(6);
        resync = 1'b1; step(); resync = 1'b0;
        pull(); chk("R6 FIFO ignores resync", int'(rd_data), 5);
        pull(); chk("R1 spare code as FIFO", int'(rd_data), 6);
        mode_sel = 2'd0;

        // R5: synchronous buffer resync
        chan_en = 1'b0; step(); chan_en = 1'b1; mode_sel = 2'd1; step();
        for (int i = 0; i < 5; i++) push(100 + i);
        pull(); pull(); chk("R5 before resync", int'(rd_data), 101);
        resync = 1'b1; step(); resync = 1'b0;
        pull(); chk("R5 read restarts at slot 0", int'(rd_data), 100);
        for (int i = 0; i < 4; i++) pull();
        chk("R5 occupancy reload", int'(rd_data), 104);
        pull(); chk("R5 empty after reload", int'(rd_valid), 0);
        clr_status = 1'b1; step(); clr_status = 1'b0;

        // R7: internally-clocked mode, start every F words
        chan_en = 1'b0; step(); chan_en = 1'b1; mode_sel = 2'd2; step();
        n_valid = 0; n_start = 0;
        rd_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            resync = i[0];
            push(200 + i);
        end
        resync = 1'b0; rd_en = 1'b0;
        repeat (3) step();
        chk("R7 words delivered", n_valid, 12);
        chk("R7 frame starts", n_start, 3);

        // R8: no start pulses outside internally-clocked mode
        mode_sel = 2'd0; n_start = 0;
        for (int i = 0; i < 6; i++) begin push(i); pull(); end
        chk("R8 no start in FIFO", n_start, 0);

        // R10 / R9: disabled channel
        chan_en = 1'b0; step();
        chk("R9 enable echo low", int'(status[0]), 0);
        push(1); push(2); push(3); pull();
        chk("R10 no valid while off", int'(rd_valid), 0);
        chk("R10 no flag while off", int'(status[1]), 0);
        chan_en = 1'b1; step();
        chk("R9 enable echo high", int'(status[0]), 1);
        pull();
        chk("R10 writes ignored while off", int'(rd_valid), 0);
        chk("R10 store empty after enable", int'(status[1]), 1);

        // Random phase across all modes
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 40) == 0) mode_sel = 2'($urandom);
            chan_en    = (($urandom % 50) != 0);
            clr_status = (($urandom % 20) == 0);
            wr_en      = (($urandom % 3) != 0);
            wr_data    = W'($urandom);
            rd_en      = (($urandom % 2) == 0);
            resync     = (($urandom % 15) == 0);
            step();
        end
        wr_en = 1'b0; rd_en = 1'b0; resync = 1'b0; clr_status = 1'b0;
        step();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule